// File: doc/BRIEF.md
# Single-Channel PCM Serial Port with Channel-Associated Signaling

This block is the digital serial edge of one voice channel in a telephone codec. Once per frame it shifts an 8-bit companded sample out on a transmit data line and gathers an 8-bit sample from a receive data line. Both directions send the most significant bit first.

The two directions are timed by separate bit-clock strobes in the system clock domain. The transmit strobe stands for the rising edges of the transmit data clock and the receive strobe for the falling edges of the receive data clock. The two strobes need not share a rate. A frame-sync input, sampled on a strobe, opens each 8-bit slot.

Some frames carry a signaling bit in the least significant position. In those frames the last transmitted bit takes the level of an external signaling input, and the last received bit is kept on a persistent signaling output. Which frames carry signaling comes from a flag sampled with frame sync, or from an internal frame count when the `SIG_PERIOD` parameter is non-zero. The port drives an output enable and an active-low time-slot strobe, so that an external 3-state buffer can drive the line. A power-enable input idles the whole port.

Top module: `pcm_sig_port`

## Requirements
- R1: After reset, `tx_oe` is 0, `tx_slot_n` is 1, `tx_sd` is 0, `rx_vld` is 0 and `rx_sig` is 0.
- R2: A `tx_fsync` of 1 sampled on a `tx_bit_en` strobe loads the held parallel word. The word goes out MSB first, one bit per strobe, with bit 7 valid from the sync strobe and bit 0 valid after the 8th strobe.
- R3: In a transmit frame flagged as signaling (`tx_sig_flag` = 1 at sync), the eighth bit on `tx_sd` equals `sig_tx`. In a frame not flagged, it is bit 0 of the word.
- R4: `tx_oe` is 1 and `tx_slot_n` is 0 from the sync strobe until the strobe after the 8th bit. Outside that window `tx_oe` is 0, `tx_slot_n` is 1 and `tx_sd` is 0.
- R5: A `rx_fsync` of 1 on a `rx_bit_en` strobe captures `rx_sd` as bit 7. The seven strobes that follow capture bits 6 to 0. One clock after the 8th strobe, `rx_word` holds the word and `rx_vld` is 1 for exactly one cycle.
- R6: `rx_sig` takes the last received bit of a frame flagged as signaling (`rx_sig_flag` = 1 at sync) and keeps it through frames that are not flagged.
- R7: A word offered on `tx_word` / `tx_word_vld` during a slot does not change that slot's bits. It goes out in the next frame.
- R8: While `pwr_up` is 0, frame syncs are ignored and `tx_oe` falls within one cycle. Any slot in progress is abandoned, no `rx_vld` is produced, and `rx_sig` is left unchanged.
- R9: Transmit and receive run from independent strobes at different rates and may overlap in time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | 1 = port active, 0 = powered down |
| tx_bit_en | input | 1 | Transmit bit strobe (data-clock rising edge) |
| tx_fsync | input | 1 | Transmit frame sync, sampled on tx_bit_en |
| tx_sig_flag | input | 1 | Marks the transmit frame as signaling, sampled with sync |
| sig_tx | input | 1 | Signaling level sent as the eighth bit in signaling frames |
| tx_word | input | 8 | Next companded sample to send |
| tx_word_vld | input | 1 | Loads tx_word into the holding register |
| tx_sd | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Output enable for the transmit line driver |
| tx_slot_n | output | 1 | Active-low time-slot strobe for an external 3-state buffer |
| rx_bit_en | input | 1 | Receive bit strobe (data-clock falling edge) |
| rx_fsync | input | 1 | Receive frame sync, sampled on rx_bit_en |
| rx_sig_flag | input | 1 | Marks the receive frame as signaling, sampled with sync |
| rx_sd | input | 1 | Receive serial data |
| rx_word | output | 8 | Last completed received sample |
| rx_vld | output | 1 | One-cycle pulse when rx_word updates |
| rx_sig | output | 1 | Persistent received signaling bit |

## Verification
The hardest case to reach is a slot that changes while it is already under way. Two examples are a parallel word that arrives after some bits have left, and a power drop in the middle of a frame. The stimulus places a `tx_word_vld` pulse after the fourth transmit strobe and checks that the remaining bits are still the old word while the next frame carries the new one. A separate frame clears `pwr_up` after three bits. Overlapping transmit and receive frames at different strobe periods check that the two directions stay independent. Alternating signaling and plain receive frames show that `rx_sig` keeps its value.

// File: rtl/pcm_sig_pkg.sv
package pcm_sig_pkg;
  localparam int unsigned PCM_BITS_DEF = 8;

  function automatic int unsigned cnt_width(input int unsigned nbits);
    return $clog2(nbits + 1);
  endfunction
endpackage

// File: rtl/pcm_frame_sel.sv
module pcm_frame_sel #(
  parameter int unsigned SIG_PERIOD = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic flag_in,
  output logic is_sig
);
  generate
    if (SIG_PERIOD == 0) begin : g_flag
      assign is_sig = flag_in;
    end else begin : g_count
      localparam int unsigned FW = (SIG_PERIOD > 1) ? $clog2(SIG_PERIOD) : 1;
      logic [FW-1:0] fcnt_q, fcnt_d;

      always_comb begin
        fcnt_d = fcnt_q;
        if (adv) begin
          if (fcnt_q == FW'(SIG_PERIOD - 1)) fcnt_d = '0;
          else                               fcnt_d = fcnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcnt_q <= '0;
        else        fcnt_q <= fcnt_d;
      end

      assign is_sig = (fcnt_q == FW'(SIG_PERIOD - 1));

      AST_FCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt_q <= FW'(SIG_PERIOD - 1)); // R6
    end
  endgenerate
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift import pcm_sig_pkg::*; #(
  parameter int unsigned DW = PCM_BITS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic          sig_frame,
  input  logic          sig_bit,
  input  logic [DW-1:0] word_in,
  input  logic          word_vld,
  output logic          start,
  output logic          sd,
  output logic          oe
);
  localparam int unsigned CW = cnt_width(DW);

  logic [DW-1:0] hold_q, hold_d, sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, sigf_q, sigf_d;

  assign start = pwr_up && bit_en && fsync;

  always_comb begin
    hold_d = hold_q;
    if (word_vld) hold_d = word_in;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    sigf_d = sigf_q;
    if (!pwr_up) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (bit_en) begin
      if (fsync) begin
        sh_d   = hold_q;
        cnt_d  = CW'(1);
        act_d  = 1'b1;
        sigf_d = sig_frame;
      end else if (act_q) begin
        if (cnt_q == CW'(DW)) begin
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          sh_d  = {sh_q[DW-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      sigf_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      sigf_q <= sigf_d;
    end
  end

  assign oe = act_q;
  assign sd = act_q ? (((cnt_q == CW'(DW)) && sigf_q) ? sig_bit : sh_q[DW-1]) : 1'b0;

  AST_TX_START_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(pwr_up && bit_en && fsync)); // R2
  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(DW))); // R4
  AST_TX_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> !act_q); // R8
  AST_TX_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sd); // R4
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift import pcm_sig_pkg::*; #(
  parameter int unsigned DW = PCM_BITS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic          sig_frame,
  input  logic          sd,
  output logic          start,
  output logic [DW-1:0] word,
  output logic          vld,
  output logic          sig
);
  localparam int unsigned CW = cnt_width(DW);

  logic [DW-1:0] sh_q, sh_d, word_q, word_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, sigf_q, sigf_d;
  logic          vld_q, vld_d, sig_q, sig_d;
  logic          last_bit;

  assign start    = pwr_up && bit_en && fsync;
  assign last_bit = pwr_up && bit_en && !fsync && act_q && (cnt_q == CW'(DW - 1));

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    sigf_d = sigf_q;
    word_d = word_q;
    sig_d  = sig_q;
    vld_d  = 1'b0;
    if (!pwr_up) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (bit_en) begin
      if (fsync) begin
        sh_d   = {sh_q[DW-2:0], sd};
        cnt_d  = CW'(1);
        act_d  = 1'b1;
        sigf_d = sig_frame;
      end else if (act_q) begin
        sh_d  = {sh_q[DW-2:0], sd};
        cnt_d = cnt_q + 1'b1;
        if (last_bit) begin
          act_d  = 1'b0;
          cnt_d  = '0;
          word_d = {sh_q[DW-2:0], sd};
          vld_d  = 1'b1;
          if (sigf_q) sig_d = sd;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      sigf_q <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
      sig_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      sigf_q <= sigf_d;
      word_q <= word_d;
      vld_q  <= vld_d;
      sig_q  <= sig_d;
    end
  end

  assign word = word_q;
  assign vld  = vld_q;
  assign sig  = sig_q;

  AST_RX_VLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R5
  AST_RX_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(last_bit && sigf_q) |=> $stable(sig_q)); // R6
  AST_RX_PD_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> !vld_q); // R8
endmodule

// File: rtl/pcm_sig_port.sv
module pcm_sig_port import pcm_sig_pkg::*; #(
  parameter int unsigned DW         = PCM_BITS_DEF,
  parameter int unsigned SIG_PERIOD = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic          tx_bit_en,
  input  logic          tx_fsync,
  input  logic          tx_sig_flag,
  input  logic          sig_tx,
  input  logic [DW-1:0] tx_word,
  input  logic          tx_word_vld,
  output logic          tx_sd,
  output logic          tx_oe,
  output logic          tx_slot_n,
  input  logic          rx_bit_en,
  input  logic          rx_fsync,
  input  logic          rx_sig_flag,
  input  logic          rx_sd,
  output logic [DW-1:0] rx_word,
  output logic          rx_vld,
  output logic          rx_sig
);
  logic tx_start, rx_start, tx_is_sig, rx_is_sig;

  pcm_frame_sel #(.SIG_PERIOD(SIG_PERIOD)) u_tx_sel (
    .clk(clk), .rst_n(rst_n), .adv(tx_start), .flag_in(tx_sig_flag), .is_sig(tx_is_sig)
  );

  pcm_frame_sel #(.SIG_PERIOD(SIG_PERIOD)) u_rx_sel (
    .clk(clk), .rst_n(rst_n), .adv(rx_start), .flag_in(rx_sig_flag), .is_sig(rx_is_sig)
  );

  pcm_tx_shift #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .bit_en(tx_bit_en), .fsync(tx_fsync),
    .sig_frame(tx_is_sig), .sig_bit(sig_tx), .word_in(tx_word), .word_vld(tx_word_vld),
    .start(tx_start), .sd(tx_sd), .oe(tx_oe)
  );

  pcm_rx_shift #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .bit_en(rx_bit_en), .fsync(rx_fsync),
    .sig_frame(rx_is_sig), .sd(rx_sd), .start(rx_start), .word(rx_word), .vld(rx_vld),
    .sig(rx_sig)
  );

  assign tx_slot_n = !tx_oe;

  AST_SLOT_FOLLOWS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_slot_n) |-> $past(tx_bit_en && tx_fsync && pwr_up)); // R4
endmodule

// File: tb/test_pcm_sig_port.sv
module test_pcm_sig_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_up, tx_bit_en, tx_fsync, tx_sig_flag, sig_tx, tx_word_vld;
  logic [7:0] tx_word;
  logic       tx_sd, tx_oe, tx_slot_n;
  logic       rx_bit_en, rx_fsync, rx_sig_flag, rx_sd;
  logic [7:0] rx_word;
  logic       rx_vld, rx_sig;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pcm_sig_port i_pcm_sig_port (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync),
    .tx_sig_flag(tx_sig_flag), .sig_tx(sig_tx), .tx_word(tx_word), .tx_word_vld(tx_word_vld),
    .tx_sd(tx_sd), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n), .rx_bit_en(rx_bit_en),
    .rx_fsync(rx_fsync), .rx_sig_flag(rx_sig_flag), .rx_sd(rx_sd), .rx_word(rx_word),
    .rx_vld(rx_vld), .rx_sig(rx_sig)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // receive monitor: pops expected words as rx_vld pulses (R5)
  always @(negedge clk) begin
    if (rst_n && rx_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R8 unexpected rx_vld", int'(rx_word), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R5 rx_word", int'(rx_word), int'(e));
      end
    end
  end

  task automatic load_word(input logic [7:0] w);
    @(negedge clk);
    tx_word = w; tx_word_vld = 1'b1;
    @(negedge clk);
    tx_word_vld = 1'b0;
  endtask

  // One transmit frame; optional mid-slot word at bit index 4, optional power drop at bit 3
  task automatic tx_frame(input logic [7:0] w, input bit sflag, input bit sbit, input int per,
                          input bit mid, input logic [7:0] mw, input bit pdrop);
    sig_tx = sbit;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (pdrop && i == 3) begin
        pwr_up = 1'b0;
        @(negedge clk);
        chk(!tx_oe && tx_slot_n, "R8 tx abort", int'(tx_oe), 0);
        pwr_up = 1'b1;
        return;
      end
      if (mid && i == 4) begin tx_word = mw; tx_word_vld = 1'b1; end
      tx_bit_en = 1'b1; tx_fsync = (i == 0); tx_sig_flag = sflag;
      @(negedge clk);
      tx_bit_en = 1'b0; tx_fsync = 1'b0; tx_sig_flag = 1'b0; tx_word_vld = 1'b0;
      if (i < 8) begin
        logic eb;
        eb = (i == 7) ? (sflag ? sbit : w[0]) : w[7-i];
        chk(tx_oe && !tx_slot_n, "R4 tx_oe in slot", int'(tx_oe), 1);
        if (i == 7) chk(tx_sd == eb, "R3 tx eighth bit", int'(tx_sd), int'(eb));
        else        chk(tx_sd == eb, "R2 tx bit", int'(tx_sd), int'(eb));
      end else begin
        chk(!tx_oe && tx_slot_n && !tx_sd, "R4 tx idle after slot", int'(tx_oe), 0);
      end
      repeat (per - 2) @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [7:0] w, input bit sflag, input int per, input bit expect_vld);
    if (expect_vld) exp_q.push_back(w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_sd = w[7-i]; rx_bit_en = 1'b1; rx_fsync = (i == 0); rx_sig_flag = sflag;
      @(negedge clk);
      rx_bit_en = 1'b0; rx_fsync = 1'b0; rx_sig_flag = 1'b0;
      repeat (per - 2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pwr_up = 1'b1; tx_bit_en = 0; tx_fsync = 0; tx_sig_flag = 0; sig_tx = 0;
    tx_word = 8'h00; tx_word_vld = 0; rx_bit_en = 0; rx_fsync = 0; rx_sig_flag = 0; rx_sd = 0;
    repeat (3) @(negedge clk);
    chk(!tx_oe && tx_slot_n && !tx_sd && !rx_vld && !rx_sig, "R1 reset state", int'(tx_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_oe && tx_slot_n && !rx_vld && !rx_sig, "R1 after release", int'(tx_oe), 0);

    // R2/R3 plain and signaling transmit frames
    load_word(8'hA5);
    tx_frame(8'hA5, 1'b0, 1'b0, 4, 1'b0, 8'h00, 1'b0);
    load_word(8'h3C);
    tx_frame(8'h3C, 1'b1, 1'b1, 3, 1'b0, 8'h00, 1'b0);
    load_word(8'hFF);
    tx_frame(8'hFF, 1'b1, 1'b0, 5, 1'b0, 8'h00, 1'b0);

    // R7 mid-slot word held to next frame
    load_word(8'h81);
    tx_frame(8'h81, 1'b0, 1'b0, 4, 1'b1, 8'h5A, 1'b0);
    tx_frame(8'h5A, 1'b0, 1'b0, 4, 1'b0, 8'h00, 1'b0);

    // R5/R6 receive and signaling bit persistence
    rx_frame(8'hC3, 1'b1, 4, 1'b1);
    chk(rx_sig == 1'b1, "R6 rx_sig set by signaling frame", int'(rx_sig), 1);
    rx_frame(8'h12, 1'b0, 5, 1'b1);
    chk(rx_sig == 1'b1, "R6 rx_sig held over plain frame", int'(rx_sig), 1);
    rx_frame(8'h7E, 1'b1, 3, 1'b1);
    chk(rx_sig == 1'b0, "R6 rx_sig cleared by signaling frame", int'(rx_sig), 0);
    chk(exp_q.size() == 0, "R5 all words received", exp_q.size(), 0);

    // R9 overlapping directions at different rates
    load_word(8'h96);
    fork
      tx_frame(8'h96, 1'b1, 1'b1, 3, 1'b0, 8'h00, 1'b0);
      rx_frame(8'h69, 1'b1, 7, 1'b1);
    join
    chk(exp_q.size() == 0, "R9 overlapped receive done", exp_q.size(), 0);
    chk(rx_sig == 1'b1, "R9 rx_sig from overlapped frame", int'(rx_sig), 1);

    // R8 power-down: syncs ignored, abort mid-slot
    pwr_up = 1'b0;
    @(negedge clk);
    tx_bit_en = 1; tx_fsync = 1;
    @(negedge clk);
    tx_bit_en = 0; tx_fsync = 0;
    chk(!tx_oe && tx_slot_n, "R8 sync ignored while down", int'(tx_oe), 0);
    rx_frame(8'h00, 1'b1, 3, 1'b0);
    chk(rx_sig == 1'b1, "R8 rx_sig unchanged while down", int'(rx_sig), 1);
    pwr_up = 1'b1;
    load_word(8'hE7);
    tx_frame(8'hE7, 1'b0, 1'b0, 4, 1'b0, 8'h00, 1'b1);
    tx_frame(8'hE7, 1'b0, 1'b0, 4, 1'b0, 8'h00, 1'b0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule